// File: doc/BRIEF.md
# SPI Serial Output with Shared Ready Indication

This block drives the serial data output pin of an SPI peripheral. A mode input selects one of two behaviours. In data-only mode the pin carries only the shifted frame. In dual-function mode the same pin also tells the host that a new result is waiting, so the board needs no separate ready wire. In that mode the pin follows the internal ready signal while chip select is low and no clock has arrived. It carries serial data once the first rising SCLK edge comes. It returns to the ready indication when the frame is finished.

A frame is either a plain 24-bit data word or a 48-bit frame that also carries a status header and a check byte. The parallel source word, the mode and the frame length are sampled when chip select falls. Each new chip-select-low period starts a fresh frame. The block runs on SCLK, and chip select high acts as its asynchronous reset. It also drives an output enable for a tri-state pad.

Top module: `spi_rdy_sdo`

## Requirements
- R1: `sdo_oe` is 1 exactly while `cs_n` is 0, and 0 while `cs_n` is 1.
- R2: With `dual_mode`=1 sampled, after `cs_n` falls and before the first rising `sclk` edge, `sdo` equals `drdy_in` and follows its changes at once.
- R3: The k-th rising `sclk` edge of a frame (k = 1..N) puts frame bit N-k on `sdo`, most significant first. The bit holds through the following falling edge.
- R4: `long_frame`=0 gives N=24 and sends `tx_word[23:0]`. `long_frame`=1 gives N=48 and sends `tx_word[47:0]`.
- R5: With `dual_mode`=1, from the N-th falling `sclk` edge until `cs_n` rises, `sdo` equals `drdy_in`. This also holds across any further `sclk` pulses.
- R6: With `dual_mode`=0, if no `sclk` pulse follows the N-th rising edge, `sdo` keeps the level of the last frame bit.
- R7: With `dual_mode`=0, every rising `sclk` edge after the N-th drives `sdo` to 0.
- R8: With `dual_mode`=0, after `cs_n` falls and before the first rising `sclk` edge, `sdo` is 0 whatever `drdy_in` does.
- R9: `tx_word`, `dual_mode` and `long_frame` are sampled at the falling edge of `cs_n`. Changing them while `cs_n` stays low does not alter the bits, the frame length or the mode of the current frame.
- R10: Raising `cs_n` in the middle of a frame abandons it. The next low period restarts at the first frame bit, with the ready indication restored before the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Active-low chip select; high resets the frame logic |
| sclk | input | 1 | Serial clock from the host |
| drdy_in | input | 1 | Synchronized internal data-ready flag (1 = ready) |
| dual_mode | input | 1 | 1 = data plus ready on the pin, 0 = data only |
| long_frame | input | 1 | 1 = 48-bit frame with header and check byte, 0 = 24-bit |
| tx_word | input | LONG_BITS (48) | Parallel word to send, right-aligned |
| sdo | output | 1 | Serial output bit |
| sdo_oe | output | 1 | Pad output enable, high while selected |

## Verification
The bound checker watches on every SCLK edge the events that need no knowledge of the data: the pad enable tracks chip select, and the pin shows the ready flag before the first edge and after the frame ends in dual mode. In data-only mode it checks that the pin is low before the first edge and after every surplus clock. Only the bench scenarios can show that the right bits leave in the right order for both frame lengths. The same holds for the last bit staying on the pin when the clock stops, for mid-frame changes of the inputs having no effect, and for an aborted frame starting over from its first bit.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;

  typedef enum logic [1:0] {
    PIN_READY = 2'd0,
    PIN_DATA  = 2'd1,
    PIN_LOW   = 2'd2
  } pin_src_e;

  // Frame length in bits for the selected format.
  function automatic int unsigned frame_len(input logic long_sel,
                                            input int unsigned short_bits,
                                            input int unsigned long_bits);
    return long_sel ? long_bits : short_bits;
  endfunction

  // Word bit index for the bit sent after `sent` earlier bits, MSB first.
  function automatic int unsigned bit_index(input int unsigned nbits,
                                            input int unsigned sent);
    return nbits - 1 - sent;
  endfunction

endpackage

// File: rtl/sdo_word_capture.sv
module sdo_word_capture #(
  parameter int unsigned LONG_BITS = 48
) (
  input  logic                 cs_n,
  input  logic                 dual_mode,
  input  logic                 long_frame,
  input  logic [LONG_BITS-1:0] tx_word,
  output logic                 dual_q,
  output logic                 long_q,
  output logic [LONG_BITS-1:0] word_q
);

  // Snapshot at selection so mid-frame input changes cannot leak in.
  always_ff @(negedge cs_n) begin
    word_q <= tx_word;
    dual_q <= dual_mode;
    long_q <= long_frame;
  end

endmodule

// File: rtl/sdo_bit_engine.sv
module sdo_bit_engine
  import spi_rdy_pkg::*;
#(
  parameter int unsigned SHORT_BITS = 24,
  parameter int unsigned LONG_BITS  = 48,
  localparam int unsigned CNT_W     = $clog2(LONG_BITS + 2)
) (
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 long_q,
  input  logic [LONG_BITS-1:0] word_q,
  output logic [CNT_W-1:0]     rise_cnt,
  output logic [CNT_W-1:0]     frame_bits,
  output logic                 data_bit,
  output logic                 started,
  output logic                 frame_done
);

  localparam int unsigned IDX_W = $clog2(LONG_BITS);

  logic            in_frame;
  logic [IDX_W-1:0] idx;

  always_comb begin
    frame_bits = CNT_W'(frame_len(long_q, SHORT_BITS, LONG_BITS));
    in_frame   = (rise_cnt < frame_bits);
    idx        = IDX_W'(bit_index(int'(frame_bits), int'(rise_cnt)));
    started    = (rise_cnt != '0);
  end

  // Rising-edge side: count edges and launch the next bit.
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      rise_cnt <= '0;
      data_bit <= 1'b0;
    end else begin
      if (rise_cnt <= frame_bits) rise_cnt <= rise_cnt + 1'b1;
      data_bit <= in_frame ? word_q[idx] : 1'b0;
    end
  end

  // Falling-edge side: the frame is complete on the N-th falling edge.
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n)                      frame_done <= 1'b0;
    else if (rise_cnt >= frame_bits) frame_done <= 1'b1;
  end

endmodule

// File: rtl/sdo_pin_select.sv
module sdo_pin_select
  import spi_rdy_pkg::*;
(
  input  logic     dual_q,
  input  logic     started,
  input  logic     frame_done,
  input  logic     drdy_in,
  input  logic     data_bit,
  output pin_src_e pin_src,
  output logic     pin_val
);

  always_comb begin
    if (dual_q) pin_src = (!started || frame_done) ? PIN_READY : PIN_DATA;
    else        pin_src = started ? PIN_DATA : PIN_LOW;
    unique case (pin_src)
      PIN_READY: pin_val = drdy_in;
      PIN_DATA:  pin_val = data_bit;
      default:   pin_val = 1'b0;
    endcase
  end

endmodule

// File: rtl/spi_rdy_sdo.sv
module spi_rdy_sdo
  import spi_rdy_pkg::*;
#(
  parameter int unsigned SHORT_BITS = 24,
  parameter int unsigned LONG_BITS  = 48
) (
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 drdy_in,
  input  logic                 dual_mode,
  input  logic                 long_frame,
  input  logic [LONG_BITS-1:0] tx_word,
  output logic                 sdo,
  output logic                 sdo_oe
);

  localparam int unsigned CNT_W = $clog2(LONG_BITS + 2);

  logic                 dual_q;
  logic                 long_q;
  logic [LONG_BITS-1:0] word_q;
  logic [CNT_W-1:0]     rise_cnt;
  logic [CNT_W-1:0]     frame_bits;
  logic                 data_bit;
  logic                 started;
  logic                 frame_done;
  pin_src_e             pin_src;

  sdo_word_capture #(.LONG_BITS(LONG_BITS)) u_cap (
    .cs_n       (cs_n),
    .dual_mode  (dual_mode),
    .long_frame (long_frame),
    .tx_word    (tx_word),
    .dual_q     (dual_q),
    .long_q     (long_q),
    .word_q     (word_q)
  );

  sdo_bit_engine #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) u_eng (
    .cs_n       (cs_n),
    .sclk       (sclk),
    .long_q     (long_q),
    .word_q     (word_q),
    .rise_cnt   (rise_cnt),
    .frame_bits (frame_bits),
    .data_bit   (data_bit),
    .started    (started),
    .frame_done (frame_done)
  );

  sdo_pin_select u_sel (
    .dual_q     (dual_q),
    .started    (started),
    .frame_done (frame_done),
    .drdy_in    (drdy_in),
    .data_bit   (data_bit),
    .pin_src    (pin_src),
    .pin_val    (sdo)
  );

  assign sdo_oe = ~cs_n;

endmodule

// File: rtl/spi_rdy_sdo_chk.sv
module spi_rdy_sdo_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             cs_n,
  input logic             sclk,
  input logic             drdy_in,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             dual_q,
  input logic             started,
  input logic             frame_done,
  input logic [CNT_W-1:0] rise_cnt,
  input logic [CNT_W-1:0] frame_bits
);

  always_comb begin
    if (!$isunknown(cs_n)) begin
      assert_oe_tracks_cs_R1: assert (sdo_oe == !cs_n);
    end
  end

  assert_ready_before_data_R2: assert property (@(posedge sclk) disable iff (cs_n)
    (dual_q && !started) |-> (sdo == drdy_in));

  assert_low_before_data_R8: assert property (@(posedge sclk) disable iff (cs_n)
    (!dual_q && !started) |-> (sdo == 1'b0));

  assert_ready_after_frame_R5: assert property (@(posedge sclk) disable iff (cs_n)
    (dual_q && frame_done) |-> (sdo == drdy_in));

  assert_extra_clocks_low_R7: assert property (@(negedge sclk) disable iff (cs_n)
    (!dual_q && (rise_cnt > frame_bits)) |-> (sdo == 1'b0));

endmodule

bind spi_rdy_sdo spi_rdy_sdo_chk #(.CNT_W($clog2(LONG_BITS + 2))) u_chk (
  .cs_n       (cs_n),
  .sclk       (sclk),
  .drdy_in    (drdy_in),
  .sdo        (sdo),
  .sdo_oe     (sdo_oe),
  .dual_q     (dual_q),
  .started    (started),
  .frame_done (frame_done),
  .rise_cnt   (rise_cnt),
  .frame_bits (frame_bits)
);

// File: tb/spi_rdy_sdo_test.sv
`timescale 1ns/1ps
module spi_rdy_sdo_test;

  localparam int SB = 24;
  localparam int LB = 48;

  logic          clk = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b0;
  logic          drdy_in = 1'b0;
  logic          dual_mode = 1'b0;
  logic          long_frame = 1'b0;
  logic [LB-1:0] tx_word = '0;
  logic          sdo;
  logic          sdo_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_rdy_sdo #(.SHORT_BITS(SB), .LONG_BITS(LB)) uut (
    .cs_n(cs_n), .sclk(sclk), .drdy_in(drdy_in), .dual_mode(dual_mode),
    .long_frame(long_frame), .tx_word(tx_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_to(input logic v);
    @(posedge clk); sclk <= v;
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [LB-1:0] w, input int n, input int k);
    return logic'((w >> (n - k)) & 1);
  endfunction

  task automatic select_low();
    @(posedge clk); cs_n <= 1'b0;
    @(negedge clk);
    chk("R1 oe low-select", sdo_oe, 1'b1);
  endtask

  task automatic deselect();
    @(posedge clk); cs_n <= 1'b1; sclk <= 1'b0;
    @(negedge clk);
    chk("R1 oe deselect", sdo_oe, 1'b0);
  endtask

  // One full frame with optional surplus clocks and mid-frame input disturbance.
  task automatic run_frame(input logic dm, input logic lf, input logic [LB-1:0] w,
                           input int extra, input bit disturb);
    int n = lf ? LB : SB;
    logic last;
    dual_mode = dm; long_frame = lf; tx_word = w;
    select_low();
    for (int t = 0; t < 2; t++) begin
      drdy_in = logic'(t); #1;
      if (dm) chk("R2 ready before first edge", sdo, drdy_in);
      else    chk("R8 low before first edge", sdo, 1'b0);
    end
    if (disturb) begin
      tx_word = ~w; dual_mode = ~dm; long_frame = ~lf;
    end
    for (int k = 1; k <= n; k++) begin
      edge_to(1'b1);
      chk(disturb ? "R9 R3 bit after rise" : "R3 R4 bit after rise", sdo, exp_bit(w, n, k));
      edge_to(1'b0);
      if (k < n || !dm) chk("R3 bit held on fall", sdo, exp_bit(w, n, k));
    end
    last = exp_bit(w, n, n);
    if (dm) begin
      for (int t = 0; t < 2; t++) begin
        drdy_in = logic'(t); #1;
        chk("R5 ready after frame", sdo, drdy_in);
      end
    end else begin
      repeat (6) @(negedge clk);
      chk("R6 last bit held", sdo, last);
    end
    for (int e = 0; e < extra; e++) begin
      drdy_in = logic'(e & 1);
      edge_to(1'b1);
      if (dm) chk("R5 ready on surplus clock", sdo, drdy_in);
      else    chk("R7 surplus clock low", sdo, 1'b0);
      edge_to(1'b0);
      if (!dm) chk("R7 surplus low on fall", sdo, 1'b0);
    end
    deselect();
  endtask

  initial begin
    logic [LB-1:0] w;
    #1;
    chk("R1 oe idle", sdo_oe, 1'b0);
    w = 48'hA5C3_0F96_1E2D;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 5; p++) begin
        w = {w[LB-2:0], w[LB-1] ^ w[LB-2] ^ w[27] ^ w[26]} ^ LB'(p * 48'h0123_4567);
        run_frame(logic'(m & 1), logic'(m >> 1), w, (p % 3) + 1, 1'b0);
      end
    end
    run_frame(1'b0, 1'b0, 48'h00_0000_800001, 2, 1'b0);
    run_frame(1'b1, 1'b1, 48'hFFFF_FFFF_FFFF, 1, 1'b0);
    run_frame(1'b0, 1'b1, 48'h0000_0000_0001, 0, 1'b0);
    run_frame(1'b1, 1'b0, 48'h0000_0055_AA5A, 2, 1'b1);
    run_frame(1'b0, 1'b1, 48'h8421_0842_1084, 2, 1'b1);
    // R10: abandon a frame after five bits, then restart.
    dual_mode = 1'b1; long_frame = 1'b0; tx_word = 48'h0000_00B7_1C39;
    select_low();
    for (int k = 1; k <= 5; k++) begin
      edge_to(1'b1); edge_to(1'b0);
    end
    deselect();
    select_low();
    drdy_in = 1'b1; #1;
    chk("R10 ready restored after abort", sdo, 1'b1);
    drdy_in = 1'b0; #1;
    chk("R10 ready restored after abort", sdo, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      edge_to(1'b1);
      chk("R10 restart from first bit", sdo, exp_bit(48'h0000_00B7_1C39, SB, k));
      edge_to(1'b0);
    end
    deselect();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule